// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog built on a down-counter. The counter steps once per tick of a programmable prescaler, and its reload value is one of four fixed period lengths. Software proves it is alive by writing a two-word key sequence. A complete sequence is a refresh: it reloads the counter and restarts the prescaler. The count period is split into four equal quarters, and a 4-bit permission mask states in which quarters a refresh is allowed. The mask may enable any set of quarters, contiguous or not. A refresh in a disabled quarter still reloads the counter but raises a refresh-error flag. If the counter runs down past zero, an underflow flag is raised.

Either flag drives one exception output, and a configuration bit picks which one: an interrupt line or a reset request. The flags are sticky until software clears them. The configuration is written after reset. The first valid refresh starts the counter and locks the configuration. A freeze option stops both the counter and the prescaler while a low-power request input is high.

Top module: `wdt_core`

## Requirements
- R1: After reset, `count` reads 0, both flags are 0, `irq` and `rst_req` are 0, and the counter does not move until the first valid refresh.
- R2: A refresh is a key write of 0x0123 followed directly by a key write of 0x3210. Any other key value written between them cancels the sequence. The first refresh starts counting, with `count` loaded to period−1.
- R3: Writes on `cfg_we` take effect only before counting starts. Once the counter runs, further configuration writes have no effect.
- R4: `cfg_period` selects the period: 0 gives 256, 1 gives 4096, 2 gives 16384 and 3 gives 65536. Reloads go to period−1.
- R5: `cfg_div` selects the tick divider: 0 gives /1, 4 gives /16, 5 gives /32, 6 gives /64, 7 gives /128, 8 gives /256 and 11 gives /2048. Every other code acts as /1. The first tick comes a full divider interval after a reload.
- R6: A tick taken while `count` is 0 sets `flag_uf` and reloads `count` to period−1. No flag is set while `count` is still above 0.
- R7: The quarter is bits [n−1:n−2] of (period−1−count), where period = 2^n. A refresh is in-window when `cfg_window[quarter]` is 1. Otherwise it sets `flag_re`. The counter reloads in both cases.
- R8: With `cfg_rst_mode`=0, `irq` is high whenever either flag is set and `rst_req` stays 0. With `cfg_rst_mode`=1 the two outputs swap roles.
- R9: A write on `clr_we` clears `flag_uf` where `clr_bits[0]`=1 and clears `flag_re` where `clr_bits[1]`=1. A flag that is already set stays set until it is cleared.
- R10: With `cfg_lp_hold`=1, `count` holds while `lp_req` is high and resumes when `lp_req` falls. With `cfg_lp_hold`=0, `lp_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | 2 | Period select code |
| cfg_div | input | 4 | Tick divider code |
| cfg_window | input | 4 | Per-quarter refresh permission mask |
| cfg_lp_hold | input | 1 | 1 = freeze counting while lp_req is high |
| cfg_rst_mode | input | 1 | 0 = interrupt response, 1 = reset request |
| key_we | input | 1 | Key write strobe |
| key_data | input | 16 | Key value |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 2 | Write-1-to-clear mask (bit0 underflow, bit1 refresh error) |
| lp_req | input | 1 | Low-power request |
| count | output | 16 | Current counter value |
| flag_uf | output | 1 | Underflow flag |
| flag_re | output | 1 | Refresh-error flag |
| irq | output | 1 | Interrupt exception output |
| rst_req | output | 1 | Reset-request exception output |

## Verification
The embedded properties check, on every cycle, the invariants that hold at all times. The count never exceeds the selected reload value, and the prescaler never passes its divider limit. The configuration stays fixed once counting has started. Every refresh reloads the counter, a frozen counter holds its value, and a set flag stays set until it is cleared. Other behaviour depends on the bench driving particular scenarios, and only those scenarios can show it. This covers the key encoding and how the sequence is cancelled, the quarter chosen for each refresh under random masks and periods, the exact cycle of an underflow, the divider step timing, and which exception output the mode selects.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W = 16;
    localparam int DIV_W = 11;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_ARM  = 16'h0123;
    localparam logic [KEY_W-1:0] KEY_FIRE = 16'h3210;

    typedef struct packed {
        logic             started;
        logic [1:0]       per_sel;
        logic [3:0]       div_sel;
        logic [3:0]       win_mask;
        logic             lp_hold;
        logic             rst_mode;
        logic [CNT_W-1:0] cnt;
        logic             uf;
        logic             re;
    } wdt_state_t;

    // reload value (period - 1) for a period select code
    function automatic logic [CNT_W-1:0] per_max_f(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(255);
            2'd1:    return CNT_W'(4095);
            2'd2:    return CNT_W'(16383);
            default: return CNT_W'(65535);
        endcase
    endfunction

    // divider minus one; undefined codes fall back to /1
    function automatic logic [DIV_W-1:0] div_max_f(input logic [3:0] code);
        case (code)
            4'd4:    return DIV_W'(15);
            4'd5:    return DIV_W'(31);
            4'd6:    return DIV_W'(63);
            4'd7:    return DIV_W'(127);
            4'd8:    return DIV_W'(255);
            4'd11:   return DIV_W'(2047);
            default: return DIV_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_W = wdt_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_max,
    output logic             tick
);
    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        if (restart) begin
            pre_d = '0;
        end else if (run) begin
            if (pre_q == div_max) begin
                pre_d = '0;
                tick  = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R5: the divider phase never passes the selected limit
    a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_q <= div_max));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
    parameter int KEY_W = wdt_pkg::KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_data,
    output logic             refresh
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        refresh = 1'b0;
        if (key_we) begin
            refresh = armed_q && (key_data == wdt_pkg::KEY_FIRE);
            armed_d = (key_data == wdt_pkg::KEY_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R2: a completed sequence consumes the arming
    a_r2_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !armed_q);
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] per_max,
    input  logic [1:0]       per_sel,
    input  logic [3:0]       win_mask,
    output logic [1:0]       quarter,
    output logic             permit
);
    logic [CNT_W-1:0] elapsed;

    always_comb begin
        elapsed = per_max - count;
        case (per_sel)
            2'd0:    quarter = elapsed[7:6];
            2'd1:    quarter = elapsed[11:10];
            2'd2:    quarter = elapsed[13:12];
            default: quarter = elapsed[CNT_W-1:CNT_W-2];
        endcase
        permit = win_mask[quarter];
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CW = wdt_pkg::CNT_W,
    parameter int DW = wdt_pkg::DIV_W,
    parameter int KW = wdt_pkg::KEY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_period,
    input  logic [3:0]    cfg_div,
    input  logic [3:0]    cfg_window,
    input  logic          cfg_lp_hold,
    input  logic          cfg_rst_mode,
    input  logic          key_we,
    input  logic [KW-1:0] key_data,
    input  logic          clr_we,
    input  logic [1:0]    clr_bits,
    input  logic          lp_req,
    output logic [CW-1:0] count,
    output logic          flag_uf,
    output logic          flag_re,
    output logic          irq,
    output logic          rst_req
);
    wdt_state_t s_d, s_q;

    logic          refresh;
    logic          tick;
    logic          run;
    logic          permit;
    logic [1:0]    quarter;
    logic [CW-1:0] per_max;
    logic [DW-1:0] div_max;

    assign per_max = per_max_f(s_q.per_sel);
    assign div_max = div_max_f(s_q.div_sel);
    assign run     = s_q.started && !(lp_req && s_q.lp_hold);

    wdt_keyseq #(.KEY_W(KW)) u_key (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
        .refresh(refresh)
    );

    wdt_prescaler #(.DIV_W(DW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(refresh),
        .div_max(div_max), .tick(tick)
    );

    wdt_window #(.CNT_W(CW)) u_win (
        .count(s_q.cnt), .per_max(per_max), .per_sel(s_q.per_sel),
        .win_mask(s_q.win_mask), .quarter(quarter), .permit(permit)
    );

    always_comb begin
        logic uf_set, re_set;
        s_d    = s_q;
        uf_set = 1'b0;
        re_set = 1'b0;
        if (!s_q.started && cfg_we) begin
            s_d.per_sel  = cfg_period;
            s_d.div_sel  = cfg_div;
            s_d.win_mask = cfg_window;
            s_d.lp_hold  = cfg_lp_hold;
            s_d.rst_mode = cfg_rst_mode;
        end
        if (refresh) begin
            s_d.cnt     = per_max;
            s_d.started = 1'b1;
            re_set      = s_q.started && !permit;
        end else if (tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = per_max;
                uf_set  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        s_d.uf = uf_set | (s_q.uf & ~(clr_we & clr_bits[0]));
        s_d.re = re_set | (s_q.re & ~(clr_we & clr_bits[1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign flag_uf = s_q.uf;
    assign flag_re = s_q.re;
    assign irq     = (s_q.uf | s_q.re) & ~s_q.rst_mode;
    assign rst_req = (s_q.uf | s_q.re) &  s_q.rst_mode;

    // R4: a running counter stays within the selected period
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.started |-> (s_q.cnt <= per_max));

    // R3: configuration is frozen once counting has begun
    a_r3_cfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.started |=> (s_q.started && $stable(s_q.per_sel) && $stable(s_q.div_sel)
                         && $stable(s_q.win_mask) && $stable(s_q.rst_mode)));

    // R7: every refresh, in window or not, reloads the counter
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (s_q.cnt == $past(per_max)));

    // R10: frozen counting holds the count
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.started && lp_req && s_q.lp_hold && !refresh) |=> $stable(s_q.cnt));

    // R9: flags are sticky until cleared
    a_r9_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.uf && !(clr_we && clr_bits[0])) |=> s_q.uf);
    a_r9_re_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.re && !(clr_we && clr_bits[1])) |=> s_q.re);
endmodule

// File: tb/wdt_core_test.sv
module wdt_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_period = '0;
    logic [3:0]  cfg_div = '0;
    logic [3:0]  cfg_window = '0;
    logic        cfg_lp_hold = 1'b0;
    logic        cfg_rst_mode = 1'b0;
    logic        key_we = 1'b0;
    logic [15:0] key_data = '0;
    logic        clr_we = 1'b0;
    logic [1:0]  clr_bits = '0;
    logic        lp_req = 1'b0;
    logic [15:0] count;
    logic        flag_uf, flag_re, irq, rst_req;

    int checks = 0;
    int fails  = 0;

    wdt_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_period(cfg_period),
        .cfg_div(cfg_div), .cfg_window(cfg_window), .cfg_lp_hold(cfg_lp_hold),
        .cfg_rst_mode(cfg_rst_mode), .key_we(key_we), .key_data(key_data),
        .clr_we(clr_we), .clr_bits(clr_bits), .lp_req(lp_req), .count(count),
        .flag_uf(flag_uf), .flag_re(flag_re), .irq(irq), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_f(input logic [1:0] sel);
        case (sel)
            2'd0: return 256;
            2'd1: return 4096;
            2'd2: return 16384;
            default: return 65536;
        endcase
    endfunction

    function automatic int quarter_f(input logic [1:0] sel, input int elapsed);
        return elapsed / (period_f(sel) / 4);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic configure(input logic [1:0] p, input logic [3:0] d, input logic [3:0] m,
                             input logic lh, input logic rm);
        cfg_we = 1'b1; cfg_period = p; cfg_div = d; cfg_window = m;
        cfg_lp_hold = lh; cfg_rst_mode = rm;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic key_write(input logic [15:0] v);
        key_we = 1'b1; key_data = v;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic do_refresh();
        key_write(16'h0123);
        key_write(16'h3210);
    endtask

    task automatic clear(input logic [1:0] b);
        clr_we = 1'b1; clr_bits = b;
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        int x;
        seed = $urandom(32'h5EED_0042);

        // R1: reset state
        do_reset();
        chk("R1", "count", count, 0);
        chk("R1", "flag_uf", flag_uf, 0);
        chk("R1", "flag_re", flag_re, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "rst_req", rst_req, 0);
        configure(2'd0, 4'd0, 4'hF, 1'b1, 1'b0);
        repeat (300) @(negedge clk);
        chk("R1", "idle count", count, 0);
        chk("R1", "idle flag_uf", flag_uf, 0);

        // R2: broken sequence does not start
        key_write(16'h0123); key_write(16'h5555); key_write(16'h3210);
        repeat (5) @(negedge clk);
        chk("R2", "broken seq count", count, 0);

        // R2 / R4: valid sequence starts with period-1
        do_refresh();
        chk("R2", "start count", count, 255);
        repeat (10) @(negedge clk);
        chk("R4", "count after 10", count, 245);

        // R3: late configuration ignored (period stays 256, mask stays all)
        configure(2'd3, 4'd11, 4'h0, 1'b0, 1'b1);
        do_refresh();
        chk("R3", "reload keeps old period", count, 255);
        chk("R3", "mask unchanged no error", flag_re, 0);
        repeat (3) @(negedge clk);
        chk("R3", "divider unchanged", count, 252);

        // R10: freeze with hold enabled
        lp_req = 1'b1;
        x = count;
        repeat (20) @(negedge clk);
        chk("R10", "frozen count", count, x);
        lp_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", "resumed count", count, x - 5);

        // R6 / R8: underflow cycle and interrupt
        do_refresh();
        repeat (255) @(negedge clk);
        chk("R6", "count at zero", count, 0);
        chk("R6", "no flag at zero", flag_uf, 0);
        @(negedge clk);
        chk("R6", "flag_uf set", flag_uf, 1);
        chk("R6", "reloaded", count, 255);
        chk("R8", "irq on underflow", irq, 1);
        chk("R8", "rst_req idle", rst_req, 0);

        // R9: clear of the other bit has no effect, own bit clears
        clear(2'b10);
        chk("R9", "uf kept", flag_uf, 1);
        clear(2'b01);
        chk("R9", "uf cleared", flag_uf, 0);
        chk("R9", "irq dropped", irq, 0);

        // R10: hold disabled -> lp_req ignored
        do_reset();
        configure(2'd0, 4'd0, 4'hF, 1'b0, 1'b0);
        do_refresh();
        lp_req = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10", "no-hold keeps counting", count, 235);
        lp_req = 1'b0;

        // R5: divide by 16
        do_reset();
        configure(2'd0, 4'd4, 4'hF, 1'b0, 1'b0);
        do_refresh();
        repeat (47) @(negedge clk);
        chk("R5", "div16 at 47", count, 253);
        @(negedge clk);
        chk("R5", "div16 at 48", count, 252);

        // R5: unused code acts as /1
        do_reset();
        configure(2'd0, 4'd2, 4'hF, 1'b0, 1'b0);
        do_refresh();
        repeat (10) @(negedge clk);
        chk("R5", "unused code /1", count, 245);

        // R7 / R8: directed out-of-window refresh, reset mode, mask 0x5
        do_reset();
        configure(2'd0, 4'd0, 4'h5, 1'b0, 1'b1);
        do_refresh();
        repeat (99) @(negedge clk);
        do_refresh();
        chk("R7", "quarter1 disabled error", flag_re, 1);
        chk("R7", "reload after error", count, 255);
        chk("R8", "rst_req on error", rst_req, 1);
        chk("R8", "irq quiet in reset mode", irq, 0);
        clear(2'b10);
        chk("R9", "re cleared", flag_re, 0);
        repeat (149) @(negedge clk);
        do_refresh();
        chk("R7", "quarter2 enabled no error", flag_re, 0);

        // R4 / R7 / R8: random windows, periods, refresh points
        for (int t = 0; t < 20; t++) begin
            logic [1:0] ps;
            logic [3:0] m;
            logic       rm;
            int p, w, q;
            ps = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
            m  = 4'($urandom % 15 + 1);
            rm = 1'($urandom % 2);
            p  = period_f(ps);
            w  = $urandom % (p - 2);
            do_reset();
            configure(ps, 4'd0, m, 1'b0, rm);
            do_refresh();
            chk("R4", "random start count", count, p - 1);
            repeat (w) @(negedge clk);
            do_refresh();
            q = quarter_f(ps, w + 1);
            chk("R7", "random window error", flag_re, m[q] ? 0 : 1);
            chk("R7", "random reload", count, p - 1);
            chk("R8", "random irq", irq, (!m[q] && !rm) ? 1 : 0);
            chk("R8", "random rst_req", rst_req, (!m[q] && rm) ? 1 : 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule